// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Check

This block keeps the in-flight loads of one thread of an out-of-order core in a circular buffer. Every dispatched load takes the slot at the tail, labelled with its sequence number (a larger number means a younger instruction). A load keeps its slot after it executes. Loads leave from the head, in order, when a commit bound arrives. A squash bound drops every load younger than the bound and pulls the tail back. Cache access and data return are not part of this block. Execution is one request that carries the load's address and size, together with the nearest older store that could forward data to it.

Two hazards are tracked. When a store resolves its address, the store is probed against every executed load that is younger than the store. If any such load touched an overlapping byte range, a violation is latched, and it names the oldest offending load. The violation stays up until a read pulse takes it. A load that an older store can feed only in part starts a stall. The stall sequencer has three named states. `LQ_RUN` is normal operation. In `LQ_STALL`, new executions are refused. `LQ_REPLAY` lasts one cycle and tells the core to issue the load again. The transitions are named as follows. *start* (RUN or REPLAY to STALL) happens on a partial-overlap execution. *drain* (STALL to REPLAY) happens when the blocking store writes back. *kill* (STALL to RUN) happens when a squash removes the stalled load. *resume* (REPLAY to RUN) happens after the replay cycle.

Top module: `load_order_queue`

## Requirements
- R1: After reset, `lq_count` is 0 and `lq_full`, `alloc_err`, `viol_flag`, `stall` and `replay_valid` are all 0.
- R2: An accepted allocation writes the load into slot `alloc_slot`, which is (head + count) mod SLOTS and is shown before the request. `lq_count` rises by one on the next cycle.
- R3: One slot is kept as a sentinel, so `lq_full` is 1 when `lq_count` equals SLOTS-1. An allocation that arrives while `lq_full` is 1 is dropped, and `alloc_err` is 1 for exactly the following cycle. The count never goes above SLOTS-1.
- R4: Executing a load never frees its slot, so `lq_count` does not change.
- R5: A commit with bound C retires every queued load whose sequence number is below C, and the head moves past them.
- R6: A squash with bound S removes every queued load whose sequence number is above S. An allocation in the same cycle as a squash is dropped, and no error is flagged for it.
- R7: An allocation and a commit in the same cycle both take effect. The new count is the old count plus one minus the number retired. Fullness is judged on the count before the commit.
- R8: A probe from a store with sequence number P, address A and size code Z (the access covers 2^Z bytes starting at A, so codes 0..3 mean 1, 2, 4 and 8 bytes) sets `viol_flag` on the next cycle when some executed load younger than P overlaps that range. `viol_seq` then gives the smallest such sequence number.
- R9: A probe raises no violation from loads that are older than the store, from loads that have not executed, or from loads whose ranges do not overlap.
- R10: A latched violation keeps `viol_flag` and `viol_seq` until `viol_read` is pulsed, and later violations do not replace it. After the read, with no new violation in that cycle, `viol_flag` is 0.
- R11: An execution whose forwarding store overlaps the load but does not cover all of its bytes raises `stall` on the next cycle, and the load stays unexecuted. While `stall` is 1, execution requests are ignored. A store that covers the load fully, or does not overlap it, causes no stall.
- R12: A write-back whose sequence number matches the blocking store ends the stall. For exactly one cycle, `replay_valid` is 1 with `replay_slot` naming the stalled load. A write-back with any other number has no effect.
- R13: A squash that removes the stalled load clears `stall` without a replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a slot for a dispatched load |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_slot | output | IDX_W | Slot the next allocation will occupy |
| exec_valid | input | 1 | A queued load executes |
| exec_idx | input | IDX_W | Slot of the executing load |
| exec_addr | input | ADDR_W | Load byte address |
| exec_size | input | 2 | Load size code (2^code bytes) |
| fwd_valid | input | 1 | An older store may forward to this load |
| fwd_seq | input | SEQ_W | Sequence number of that store |
| fwd_addr | input | ADDR_W | Address of that store |
| fwd_size | input | 2 | Size code of that store |
| commit_valid | input | 1 | Commit bound present |
| commit_seq | input | SEQ_W | Loads below this number retire |
| squash_valid | input | 1 | Squash bound present |
| squash_seq | input | SEQ_W | Loads above this number are removed |
| probe_valid | input | 1 | A store has resolved its address |
| probe_seq | input | SEQ_W | Sequence number of the probing store |
| probe_addr | input | ADDR_W | Address of the probing store |
| probe_size | input | 2 | Size code of the probing store |
| wb_valid | input | 1 | A store has written back |
| wb_seq | input | SEQ_W | Sequence number of the written-back store |
| viol_read | input | 1 | Consume the latched violation |
| lq_count | output | CNT_W | Number of queued loads |
| lq_full | output | 1 | Queue holds SLOTS-1 loads |
| alloc_err | output | 1 | Previous allocation was refused while full |
| viol_flag | output | 1 | Ordering violation latched |
| viol_seq | output | SEQ_W | Sequence number of the violating load |
| stall | output | 1 | Partial-overlap stall in progress |
| replay_valid | output | 1 | Stalled load must be reissued |
| replay_slot | output | IDX_W | Slot of the load to reissue |

## Verification
Allocation and commit can happen in the same cycle, and so can allocation and squash. These are the cases where a tail update and a head update or tail retraction meet. The bench drives an allocation together with a commit bound that retires one load, and checks that the count stays level and that the new load sits at the pre-computed slot. It then drives an allocation together with a squash bound, and checks that the count drops by exactly the squashed loads and that no error is flagged. A separate sequence pairs an execution with an active stall, and checks at the ports that the refused execution left its load unexecuted: a later probe finds no violation there.

// File: rtl/lq_pkg.sv
package lq_pkg;

    typedef enum logic [1:0] {
        LQ_RUN    = 2'd0,
        LQ_STALL  = 2'd1,
        LQ_REPLAY = 2'd2
    } lq_state_e;

    typedef logic [1:0] lq_size_t;

endpackage

// File: rtl/lq_span_cmp.sv
module lq_span_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [1:0]        a_size,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [1:0]        b_size,
    output logic              overlap
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo    = {1'b0, a_addr};
        b_lo    = {1'b0, b_addr};
        a_hi    = a_lo + (EXT_W'(1) << a_size);
        b_hi    = b_lo + (EXT_W'(1) << b_size);
        overlap = (a_lo < b_hi) && (b_lo < a_hi);
    end
endmodule

// File: rtl/lq_scan.sv
module lq_scan #(
    parameter int SLOTS = 5,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [IDX_W-1:0]            head,
    input  logic [SLOTS-1:0]            occ,
    input  logic [SLOTS-1:0][SEQ_W-1:0] seqs,
    input  logic [SLOTS-1:0]            hit,
    input  logic                        commit_valid,
    input  logic [SEQ_W-1:0]            commit_seq,
    input  logic                        squash_valid,
    input  logic [SEQ_W-1:0]            squash_seq,
    output logic [CNT_W-1:0]            retire_n,
    output logic [CNT_W-1:0]            keep_n,
    output logic                        vio_found,
    output logic [SEQ_W-1:0]            vio_seq
);
    function automatic logic [IDX_W-1:0] wrap(input logic [IDX_W:0] v);
        return (v >= (IDX_W+1)'(SLOTS)) ? IDX_W'(v - (IDX_W+1)'(SLOTS)) : IDX_W'(v);
    endfunction

    always_comb begin
        retire_n = '0;
        keep_n   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (occ[i]) begin
                if (commit_valid && (seqs[i] < commit_seq))
                    retire_n = retire_n + CNT_W'(1);
                else if (!squash_valid || (seqs[i] <= squash_seq))
                    keep_n = keep_n + CNT_W'(1);
            end
        end
    end

    // Walk from youngest offset to oldest so the oldest hit wins.
    always_comb begin
        logic [IDX_W-1:0] s;
        vio_found = 1'b0;
        vio_seq   = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            s = wrap({1'b0, head} + (IDX_W+1)'(k));
            if (occ[s] && hit[s]) begin
                vio_found = 1'b1;
                vio_seq   = seqs[s];
            end
        end
    end
endmodule

// File: rtl/lq_stall_fsm.sv
module lq_stall_fsm
    import lq_pkg::*;
#(
    parameter int SLOTS = 5,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_slot,
    input  logic [SEQ_W-1:0] start_ld_seq,
    input  logic [SEQ_W-1:0] start_st_seq,
    input  logic             wb_valid,
    input  logic [SEQ_W-1:0] wb_seq,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    output logic             stall,
    output logic             replay_valid,
    output logic [IDX_W-1:0] replay_slot
);
    lq_state_e        state_q, state_d;
    logic [IDX_W-1:0] slot_q;
    logic [SEQ_W-1:0] ldseq_q, stseq_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LQ_RUN:    if (start) state_d = LQ_STALL;
            LQ_STALL: begin
                if (squash_valid && (ldseq_q > squash_seq))
                    state_d = LQ_RUN;
                else if (wb_valid && (wb_seq == stseq_q))
                    state_d = LQ_REPLAY;
            end
            LQ_REPLAY: state_d = start ? LQ_STALL : LQ_RUN;
            default:   state_d = LQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LQ_RUN;
            slot_q  <= '0;
            ldseq_q <= '0;
            stseq_q <= '0;
        end else begin
            state_q <= state_d;
            if (start && (state_q != LQ_STALL)) begin
                slot_q  <= start_slot;
                ldseq_q <= start_ld_seq;
                stseq_q <= start_st_seq;
            end
        end
    end

    always_comb begin
        stall        = 1'b0;
        replay_valid = 1'b0;
        replay_slot  = slot_q;
        unique case (state_q)
            LQ_RUN:    ;
            LQ_STALL:  stall = 1'b1;
            LQ_REPLAY: replay_valid = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/load_order_queue.sv
module load_order_queue #(
    parameter int SLOTS  = 5,
    parameter int SEQ_W  = 16,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    output logic [IDX_W-1:0]  alloc_slot,
    input  logic              exec_valid,
    input  logic [IDX_W-1:0]  exec_idx,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [1:0]        exec_size,
    input  logic              fwd_valid,
    input  logic [SEQ_W-1:0]  fwd_seq,
    input  logic [ADDR_W-1:0] fwd_addr,
    input  logic [1:0]        fwd_size,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              probe_valid,
    input  logic [SEQ_W-1:0]  probe_seq,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic [1:0]        probe_size,
    input  logic              wb_valid,
    input  logic [SEQ_W-1:0]  wb_seq,
    input  logic              viol_read,
    output logic [CNT_W-1:0]  lq_count,
    output logic              lq_full,
    output logic              alloc_err,
    output logic              viol_flag,
    output logic [SEQ_W-1:0]  viol_seq,
    output logic              stall,
    output logic              replay_valid,
    output logic [IDX_W-1:0]  replay_slot
);
    localparam int EXT_W = ADDR_W + 1;

    logic [SLOTS-1:0][SEQ_W-1:0]  seq_q;
    logic [SLOTS-1:0][ADDR_W-1:0] addr_q;
    logic [SLOTS-1:0][1:0]        size_q;
    logic [SLOTS-1:0]             exe_q;
    logic [IDX_W-1:0]             head_q;
    logic [CNT_W-1:0]             count_q;
    logic                         err_q, viol_q;
    logic [SEQ_W-1:0]             vseq_q;

    logic [SLOTS-1:0]  occ, ovl, hit;
    logic [IDX_W-1:0]  tail, head_nx;
    logic [CNT_W-1:0]  retire_n, keep_n;
    logic              vio_found, full, alloc_ok, exec_ok, partial;
    logic              fwd_ovl, fwd_cover;
    logic [SEQ_W-1:0]  vio_seq;

    function automatic logic [IDX_W-1:0] wrap(input logic [IDX_W:0] v);
        return (v >= (IDX_W+1)'(SLOTS)) ? IDX_W'(v - (IDX_W+1)'(SLOTS)) : IDX_W'(v);
    endfunction

    always_comb begin
        occ = '0;
        for (int k = 0; k < SLOTS; k++)
            if (CNT_W'(k) < count_q)
                occ[wrap({1'b0, head_q} + (IDX_W+1)'(k))] = 1'b1;
    end

    assign full     = (count_q == CNT_W'(SLOTS - 1));
    assign tail     = wrap({1'b0, head_q} + (IDX_W+1)'(count_q));
    assign alloc_ok = alloc_valid && !squash_valid && !full;
    assign head_nx  = wrap({1'b0, head_q} + (IDX_W+1)'(retire_n));

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_probe
            lq_span_cmp #(.ADDR_W(ADDR_W)) u_cmp (
                .a_addr (probe_addr),
                .a_size (probe_size),
                .b_addr (addr_q[g]),
                .b_size (size_q[g]),
                .overlap(ovl[g])
            );
            assign hit[g] = probe_valid && exe_q[g] && (seq_q[g] > probe_seq) && ovl[g];
        end
    endgenerate

    lq_span_cmp #(.ADDR_W(ADDR_W)) u_fwd_cmp (
        .a_addr (fwd_addr),
        .a_size (fwd_size),
        .b_addr (exec_addr),
        .b_size (exec_size),
        .overlap(fwd_ovl)
    );

    always_comb begin
        logic [EXT_W-1:0] s_lo, s_hi, l_lo, l_hi;
        s_lo      = {1'b0, fwd_addr};
        l_lo      = {1'b0, exec_addr};
        s_hi      = s_lo + (EXT_W'(1) << fwd_size);
        l_hi      = l_lo + (EXT_W'(1) << exec_size);
        fwd_cover = (s_lo <= l_lo) && (l_hi <= s_hi);
    end

    assign exec_ok = exec_valid && occ[exec_idx] && !stall;
    assign partial = fwd_valid && fwd_ovl && !fwd_cover;

    lq_scan #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) u_scan (
        .head        (head_q),
        .occ         (occ),
        .seqs        (seq_q),
        .hit         (hit),
        .commit_valid(commit_valid),
        .commit_seq  (commit_seq),
        .squash_valid(squash_valid),
        .squash_seq  (squash_seq),
        .retire_n    (retire_n),
        .keep_n      (keep_n),
        .vio_found   (vio_found),
        .vio_seq     (vio_seq)
    );

    lq_stall_fsm #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (exec_ok && partial),
        .start_slot  (exec_idx),
        .start_ld_seq(seq_q[exec_idx]),
        .start_st_seq(fwd_seq),
        .wb_valid    (wb_valid),
        .wb_seq      (wb_seq),
        .squash_valid(squash_valid),
        .squash_seq  (squash_seq),
        .stall       (stall),
        .replay_valid(replay_valid),
        .replay_slot (replay_slot)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q   <= '0;
            addr_q  <= '0;
            size_q  <= '0;
            exe_q   <= '0;
            head_q  <= '0;
            count_q <= '0;
            err_q   <= 1'b0;
            viol_q  <= 1'b0;
            vseq_q  <= '0;
        end else begin
            head_q  <= head_nx;
            count_q <= keep_n + CNT_W'(alloc_ok);
            err_q   <= alloc_valid && !squash_valid && full;
            if (alloc_ok) begin
                seq_q[tail] <= alloc_seq;
                exe_q[tail] <= 1'b0;
            end
            if (exec_ok) begin
                addr_q[exec_idx] <= exec_addr;
                size_q[exec_idx] <= exec_size;
                exe_q[exec_idx]  <= !partial;
            end
            if (vio_found && (!viol_q || viol_read)) begin
                viol_q <= 1'b1;
                vseq_q <= vio_seq;
            end else if (viol_read) begin
                viol_q <= 1'b0;
            end
        end
    end

    assign alloc_slot = tail;
    assign lq_count   = count_q;
    assign lq_full    = full;
    assign alloc_err  = err_q;
    assign viol_flag  = viol_q;
    assign viol_seq   = vseq_q;
endmodule

// File: rtl/lq_checker.sv
module lq_checker #(
    parameter int SLOTS = 5,
    parameter int SEQ_W = 16,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             exec_valid,
    input logic             commit_valid,
    input logic             squash_valid,
    input logic             probe_valid,
    input logic             wb_valid,
    input logic             viol_read,
    input logic [CNT_W-1:0] lq_count,
    input logic             lq_full,
    input logic             alloc_err,
    input logic             viol_flag,
    input logic [SEQ_W-1:0] viol_seq,
    input logic             stall,
    input logic             replay_valid
);
    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lq_count <= CNT_W'(SLOTS - 1));

    // R3
    full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lq_full && alloc_valid && !squash_valid && !commit_valid
        |=> alloc_err && (lq_count == $past(lq_count)));

    // R2
    alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lq_full && alloc_valid && !squash_valid && !commit_valid
        |=> lq_count == $past(lq_count) + CNT_W'(1));

    // R4
    exec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid && !alloc_valid && !commit_valid && !squash_valid
        |=> lq_count == $past(lq_count));

    // R10
    viol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag && !viol_read |=> viol_flag && $stable(viol_seq));

    // R10
    viol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag && viol_read && !probe_valid |=> !viol_flag);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall && !wb_valid && !squash_valid |=> stall);

    // R12
    replay_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |=> !replay_valid);

    // R12
    replay_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(replay_valid) |-> $past(stall));
endmodule

bind load_order_queue lq_checker #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) u_chk (.*);

// File: tb/load_order_queue_test.sv
`timescale 1ns/1ps
module load_order_queue_test;
    localparam int SLOTS = 5, SEQ_W = 16, ADDR_W = 16;
    localparam int IDX_W = $clog2(SLOTS), CNT_W = $clog2(SLOTS + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, exec_valid = 0, fwd_valid = 0, commit_valid = 0;
    logic squash_valid = 0, probe_valid = 0, wb_valid = 0, viol_read = 0;
    logic [SEQ_W-1:0] alloc_seq = 0, fwd_seq = 0, commit_seq = 0, squash_seq = 0, probe_seq = 0, wb_seq = 0;
    logic [ADDR_W-1:0] exec_addr = 0, fwd_addr = 0, probe_addr = 0;
    logic [1:0] exec_size = 0, fwd_size = 0, probe_size = 0;
    logic [IDX_W-1:0] exec_idx = 0;
    logic [IDX_W-1:0] alloc_slot, replay_slot;
    logic [CNT_W-1:0] lq_count;
    logic lq_full, alloc_err, viol_flag, stall, replay_valid;
    logic [SEQ_W-1:0] viol_seq;

    load_order_queue #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) uut (.*);

    always #10 clk = ~clk;

    typedef struct {
        string tag;
        logic [26:0] exp;
    } item_t;

    item_t sb[$];
    int n_chk = 0, n_bad = 0;

    function automatic logic [26:0] pack(int cnt, bit err, bit viol, int vseq, bit stl, bit rep, int ridx);
        return {CNT_W'(cnt), (cnt == SLOTS - 1), err, viol, viol ? SEQ_W'(vseq) : SEQ_W'(0),
                stl, rep, rep ? IDX_W'(ridx) : IDX_W'(0)};
    endfunction

    function automatic void check(string tag, logic [26:0] got, logic [26:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endfunction

    // Monitor: compares outputs after each edge against the scoreboard.
    initial forever begin
        @(posedge clk);
        #5;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, pack(int'(lq_count), alloc_err, viol_flag, int'(viol_seq),
                               stall, replay_valid, int'(replay_slot)), it.exp);
        end
    end

    task automatic tick(string tag, int cnt, bit err, bit viol, int vseq, bit stl, bit rep, int ridx);
        item_t it;
        it.tag = tag;
        it.exp = pack(cnt, err, viol, vseq, stl, rep, ridx);
        sb.push_back(it);
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 0; exec_valid = 0; fwd_valid = 0; commit_valid = 0;
        squash_valid = 0; probe_valid = 0; wb_valid = 0; viol_read = 0;
    endtask

    task automatic slot_is(string tag, int exp);
        check(tag, 27'(alloc_slot), 27'(exp));
    endtask

    task automatic alloc(int s);
        alloc_valid = 1; alloc_seq = SEQ_W'(s);
    endtask
    task automatic exec(int i, int a, int z);
        exec_valid = 1; exec_idx = IDX_W'(i); exec_addr = ADDR_W'(a); exec_size = 2'(z);
    endtask
    task automatic fwd(int s, int a, int z);
        fwd_valid = 1; fwd_seq = SEQ_W'(s); fwd_addr = ADDR_W'(a); fwd_size = 2'(z);
    endtask
    task automatic probe(int s, int a, int z);
        probe_valid = 1; probe_seq = SEQ_W'(s); probe_addr = ADDR_W'(a); probe_size = 2'(z);
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick("R1 reset state", 0, 0, 0, 0, 0, 0, 0);
        // R2 fill the queue, slot shown before each request
        slot_is("R2 slot 0", 0); alloc(10); tick("R2 alloc 10", 1, 0, 0, 0, 0, 0, 0);
        slot_is("R2 slot 1", 1); alloc(20); tick("R2 alloc 20", 2, 0, 0, 0, 0, 0, 0);
        slot_is("R2 slot 2", 2); alloc(30); tick("R2 alloc 30", 3, 0, 0, 0, 0, 0, 0);
        slot_is("R2 slot 3", 3); alloc(40); tick("R3 reaches full", 4, 0, 0, 0, 0, 0, 0);
        alloc(50); tick("R3 alloc while full", 4, 1, 0, 0, 0, 0, 0);
        tick("R3 error is one cycle", 4, 0, 0, 0, 0, 0, 0);
        // R4 executions keep the slots
        exec(1, 'h100, 2); tick("R4 exec seq20", 4, 0, 0, 0, 0, 0, 0);
        exec(2, 'h200, 0); tick("R4 exec seq30", 4, 0, 0, 0, 0, 0, 0);
        exec(3, 'h104, 3); tick("R4 exec seq40", 4, 0, 0, 0, 0, 0, 0);
        // R9 probes with no conflict
        probe(15, 'h300, 2); tick("R9 disjoint range", 4, 0, 0, 0, 0, 0, 0);
        probe(35, 'h102, 1); tick("R9 older load only", 4, 0, 0, 0, 0, 0, 0);
        // R8 two younger loads overlap, oldest reported
        probe(5, 'h100, 3); tick("R8 oldest violator", 4, 0, 1, 20, 0, 0, 0);
        probe(25, 'h200, 0); tick("R10 later violation kept out", 4, 0, 1, 20, 0, 0, 0);
        viol_read = 1; tick("R10 read clears", 4, 0, 0, 0, 0, 0, 0);
        // R5 commit retires two
        commit_valid = 1; commit_seq = 25; tick("R5 commit below 25", 2, 0, 0, 0, 0, 0, 0);
        // R7 allocate and commit together
        slot_is("R7 slot before", 4);
        alloc(50); commit_valid = 1; commit_seq = 35;
        tick("R7 alloc with commit", 2, 0, 0, 0, 0, 0, 0);
        // R6 squash drops younger load and same-cycle alloc
        alloc(60); squash_valid = 1; squash_seq = 45;
        tick("R6 squash with alloc", 1, 0, 0, 0, 0, 0, 0);
        slot_is("R6 tail retracted", 4); alloc(60); tick("R2 alloc 60", 2, 0, 0, 0, 0, 0, 0);
        slot_is("R2 wrap slot", 0); alloc(70); tick("R2 alloc 70", 3, 0, 0, 0, 0, 0, 0);
        // R11 partial forwarding stalls
        exec(4, 'h400, 2); fwd(55, 'h402, 1); tick("R11 partial stall", 3, 0, 0, 0, 1, 0, 0);
        exec(0, 'h500, 0); tick("R11 exec while stalled", 3, 0, 0, 0, 1, 0, 0);
        wb_valid = 1; wb_seq = 99; tick("R12 other writeback", 3, 0, 0, 0, 1, 0, 0);
        wb_valid = 1; wb_seq = 55; tick("R12 replay", 3, 0, 0, 0, 0, 1, 4);
        tick("R12 replay one cycle", 3, 0, 0, 0, 0, 0, 0);
        probe(65, 'h500, 0); tick("R11 ignored exec left unexecuted", 3, 0, 0, 0, 0, 0, 0);
        exec(0, 'h500, 0); fwd(65, 'h500, 2); tick("R11 full cover no stall", 3, 0, 0, 0, 0, 0, 0);
        probe(65, 'h500, 0); tick("R8 violation seq70", 3, 0, 1, 70, 0, 0, 0);
        viol_read = 1; tick("R10 read clears again", 3, 0, 0, 0, 0, 0, 0);
        // R13 squash kills stalled load
        exec(4, 'h600, 2); fwd(58, 'h603, 2); tick("R13 stall again", 3, 0, 0, 0, 1, 0, 0);
        squash_valid = 1; squash_seq = 55; tick("R13 squash ends stall", 1, 0, 0, 0, 0, 0, 0);
        tick("R13 no replay follows", 1, 0, 0, 0, 0, 0, 0);
        commit_valid = 1; commit_seq = 100; tick("R5 drain", 0, 0, 0, 0, 0, 0, 0);
        @(posedge clk); #6;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule